// File: doc/BRIEF.md
# DRAM Bank Request Sequencer

This block carries one queued DRAM request from acceptance to its column command. When it takes a request, it checks what the target bank holds. Its own record of the row it last opened comes first. The open-row report from a neighbouring machine is used second. From that check it picks one of three paths:

- **Hit:** the wanted row is already open, so the block goes straight to column arbitration.
- **Closed:** the bank is closed, so it requests an activate first.
- **Conflict:** another row is open, so it requests a precharge, waits the precharge time, and then requests an activate.

Row and column requests go to external arbiters. A grant is honoured only in a cycle where the matching request is raised. The precharge-to-activate wait (`T_RP`) and the activate-to-column wait (`T_RCD`) are parameters counted in controller cycles. Both must be at least 1. While a refresh runs, no row request is raised. A column request is raised only when an external qualifier reports that DRAM state, data bus, priority and ordering all allow it.

Top module: `bank_req_machine`

## Requirements
- R1: After reset, `idle` is 1 and `row_req` and `col_req` are 0. Reset clears the own open-row record, so the first request with no neighbour report of an open row takes the activate path.
- R2: A request is a hit when the bank is open on the requested row. The bank's state is taken from the own record when that record names the same rank and bank. Otherwise it is taken from the neighbour report (`nbr_open`=1 with equal rank and bank). On a hit, `col_req` is raised in the cycle after acceptance and no row request is made.
- R3: If the bank is open on a different row, the first row request is a precharge (`row_is_act`=0). An activate (`row_is_act`=1) follows.
- R4: If the bank is neither in the own record nor reported open by the neighbour, the first row request is an activate.
- R5: Let a precharge be granted in cycle c. The activate request is first raised in cycle c+T_RP+1, and no request is raised in between.
- R6: Let an activate be granted in cycle c. With `col_allowed` held at 1, `col_req` is first raised in cycle c+T_RCD+1, and no request is raised in between.
- R7: While `refresh_busy` is 1, `row_req` is 0. A `row_grant` during that time is ignored. The same row request reappears once the refresh ends.
- R8: `col_req` is raised only while `col_allowed` is 1. Every request issues exactly one column command, and `col_is_write` equals the request's write flag.
- R9: Let the column command be granted in cycle c. In cycle c+1 the block raises no request and `idle` is 0. In cycle c+2 `idle` is 1.
- R10: `cmd_rank`, `cmd_bank`, `cmd_row` and `cmd_col` carry the accepted request until `idle` returns. A `req_valid` while not idle is ignored.
- R11: A granted activate records the rank, bank and row in the own record. A granted precharge clears the own record when it names the same rank and bank. When both the own record and the neighbour report cover the bank, the own record wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New request offered; taken when `idle` is 1 |
| req_rank | input | RANK_W | Request rank |
| req_bank | input | BANK_W | Request bank |
| req_row | input | ROW_W | Request row |
| req_col | input | COL_W | Request column |
| req_write | input | 1 | 1 = write, 0 = read |
| idle | output | 1 | Ready to accept a request |
| refresh_busy | input | 1 | Refresh in progress; row requests held |
| nbr_open | input | 1 | Neighbour reports an open row |
| nbr_rank | input | RANK_W | Rank of the neighbour's open row |
| nbr_bank | input | BANK_W | Bank of the neighbour's open row |
| nbr_row | input | ROW_W | Neighbour's open row |
| row_req | output | 1 | Row command arbitration request |
| row_grant | input | 1 | Row arbiter grant |
| row_is_act | output | 1 | 1 = activate, 0 = precharge |
| col_req | output | 1 | Column command arbitration request |
| col_grant | input | 1 | Column arbiter grant |
| col_allowed | input | 1 | Column qualifiers all favourable |
| col_is_write | output | 1 | 1 = CAS write, 0 = CAS read |
| cmd_rank | output | RANK_W | Command rank |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Command row |
| cmd_col | output | COL_W | Command column |

## Verification
Two events can fall in the same cycle:

- **Refresh and row grant.** A refresh and a row-arbiter grant can coincide. The bench raises `row_grant` while `refresh_busy` is held during a pending precharge. It then expects `row_req` to stay low, the same precharge to reappear after the refresh, and the later precharge wait to still measure exactly `T_RP`.
- **Column block and new request.** A blocked column qualifier can meet a new `req_valid` while the block is busy. The bench pulses `req_valid` with altered fields during that window. It expects `col_req` to stay low and the command fields to be unchanged.

// File: rtl/bm_pkg.sv
package bm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_REQ,
        ST_PRE_WAIT,
        ST_ACT_REQ,
        ST_RCD_WAIT,
        ST_CAS_REQ,
        ST_DONE
    } bm_state_e;

    typedef enum logic [1:0] {
        BANK_CLOSED,
        BANK_HIT,
        BANK_CONFLICT
    } bank_verdict_e;

    function automatic bank_verdict_e classify(input logic bank_known, input logic row_same);
        if (!bank_known) return BANK_CLOSED;
        return row_same ? BANK_HIT : BANK_CONFLICT;
    endfunction

    function automatic bm_state_e entry_state(input bank_verdict_e v);
        case (v)
            BANK_HIT:      return ST_CAS_REQ;
            BANK_CONFLICT: return ST_PRE_REQ;
            default:       return ST_ACT_REQ;
        endcase
    endfunction

    function automatic logic is_row_state(input bm_state_e s);
        return (s == ST_PRE_REQ) || (s == ST_ACT_REQ);
    endfunction

endpackage

// File: rtl/bm_delay_timer.sv
module bm_delay_timer #(
    parameter int DELAY = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CW = $clog2(DELAY + 1);
    localparam logic [CW-1:0] START = CW'(DELAY - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= START;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/bm_open_row.sv
module bm_open_row
    import bm_pkg::*;
#(
    parameter int RANK_W = 1,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [RANK_W-1:0] upd_rank,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [ROW_W-1:0]  upd_row,
    input  logic [RANK_W-1:0] q_rank,
    input  logic [BANK_W-1:0] q_bank,
    input  logic [ROW_W-1:0]  q_row,
    input  logic              nbr_open,
    input  logic [RANK_W-1:0] nbr_rank,
    input  logic [BANK_W-1:0] nbr_bank,
    input  logic [ROW_W-1:0]  nbr_row,
    output bank_verdict_e     verdict
);
    logic              own_v;
    logic [RANK_W-1:0] own_rank;
    logic [BANK_W-1:0] own_bank;
    logic [ROW_W-1:0]  own_row;

    logic own_upd_match;
    assign own_upd_match = own_v && (own_rank == upd_rank) && (own_bank == upd_bank);

    always_ff @(posedge clk) begin
        if (rst) begin
            own_v    <= 1'b0;
            own_rank <= '0;
            own_bank <= '0;
            own_row  <= '0;
        end else if (set_en) begin
            own_v    <= 1'b1;
            own_rank <= upd_rank;
            own_bank <= upd_bank;
            own_row  <= upd_row;
        end else if (clr_en && own_upd_match) begin
            own_v <= 1'b0;
        end
    end

    logic own_hit_bank, nbr_hit_bank;
    assign own_hit_bank = own_v && (own_rank == q_rank) && (own_bank == q_bank);
    assign nbr_hit_bank = nbr_open && (nbr_rank == q_rank) && (nbr_bank == q_bank);

    always_comb begin
        if (own_hit_bank)
            verdict = classify(1'b1, own_row == q_row);
        else if (nbr_hit_bank)
            verdict = classify(1'b1, nbr_row == q_row);
        else
            verdict = classify(1'b0, 1'b0);
    end
endmodule

// File: rtl/bank_req_machine.sv
module bank_req_machine
    import bm_pkg::*;
#(
    parameter int RANK_W = 1,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14,
    parameter int COL_W  = 10,
    parameter int T_RP   = 3,
    parameter int T_RCD  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [RANK_W-1:0] req_rank,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_write,
    output logic              idle,
    input  logic              refresh_busy,
    input  logic              nbr_open,
    input  logic [RANK_W-1:0] nbr_rank,
    input  logic [BANK_W-1:0] nbr_bank,
    input  logic [ROW_W-1:0]  nbr_row,
    output logic              row_req,
    input  logic              row_grant,
    output logic              row_is_act,
    output logic              col_req,
    input  logic              col_grant,
    input  logic              col_allowed,
    output logic              col_is_write,
    output logic [RANK_W-1:0] cmd_rank,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col
);
    typedef struct packed {
        logic [RANK_W-1:0] rank;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              write;
    } bm_req_t;

    bm_state_e     state_q, state_d;
    bm_req_t       req_q;
    bank_verdict_e verdict;
    logic          pre_granted, act_granted, col_granted;
    logic          rp_done, rcd_done;
    logic          accept;

    assign accept      = (state_q == ST_IDLE) && req_valid;
    assign row_req     = is_row_state(state_q) && !refresh_busy;
    assign row_is_act  = (state_q == ST_ACT_REQ);
    assign col_req     = (state_q == ST_CAS_REQ) && col_allowed;
    assign pre_granted = row_req && row_grant && (state_q == ST_PRE_REQ);
    assign act_granted = row_req && row_grant && (state_q == ST_ACT_REQ);
    assign col_granted = col_req && col_grant;
    assign idle        = (state_q == ST_IDLE);

    bm_open_row #(
        .RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W)
    ) u_open_row (
        .clk      (clk),
        .rst      (rst),
        .set_en   (act_granted),
        .clr_en   (pre_granted),
        .upd_rank (req_q.rank),
        .upd_bank (req_q.bank),
        .upd_row  (req_q.row),
        .q_rank   (req_rank),
        .q_bank   (req_bank),
        .q_row    (req_row),
        .nbr_open (nbr_open),
        .nbr_rank (nbr_rank),
        .nbr_bank (nbr_bank),
        .nbr_row  (nbr_row),
        .verdict  (verdict)
    );

    bm_delay_timer #(.DELAY(T_RP)) u_rp_timer (
        .clk(clk), .rst(rst), .load(pre_granted), .expired(rp_done)
    );

    bm_delay_timer #(.DELAY(T_RCD)) u_rcd_timer (
        .clk(clk), .rst(rst), .load(act_granted), .expired(rcd_done)
    );

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:     if (accept)      state_d = entry_state(verdict);
            ST_PRE_REQ:  if (pre_granted) state_d = ST_PRE_WAIT;
            ST_PRE_WAIT: if (rp_done)     state_d = ST_ACT_REQ;
            ST_ACT_REQ:  if (act_granted) state_d = ST_RCD_WAIT;
            ST_RCD_WAIT: if (rcd_done)    state_d = ST_CAS_REQ;
            ST_CAS_REQ:  if (col_granted) state_d = ST_DONE;
            ST_DONE:                      state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                req_q <= '{rank: req_rank, bank: req_bank, row: req_row,
                           col: req_col, write: req_write};
            end
        end
    end

    assign cmd_rank     = req_q.rank;
    assign cmd_bank     = req_q.bank;
    assign cmd_row      = req_q.row;
    assign cmd_col      = req_q.col;
    assign col_is_write = req_q.write;
endmodule

// File: rtl/bm_checker.sv
module bm_checker #(
    parameter int ROW_W = 14,
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             idle,
    input logic             refresh_busy,
    input logic             row_req,
    input logic             row_grant,
    input logic             row_is_act,
    input logic             col_req,
    input logic             col_grant,
    input logic             col_allowed,
    input logic [ROW_W-1:0] cmd_row,
    input logic [COL_W-1:0] cmd_col
);
    assert_refresh_blocks_row_R7: assert property (@(posedge clk) disable iff (rst)
        refresh_busy |-> !row_req);

    assert_col_qualified_R8: assert property (@(posedge clk) disable iff (rst)
        col_req |-> col_allowed);

    assert_single_request_R8: assert property (@(posedge clk) disable iff (rst)
        !(row_req && col_req));

    assert_precharge_wait_R5: assert property (@(posedge clk) disable iff (rst)
        (row_req && row_grant && !row_is_act) |=> (!row_req && !col_req));

    assert_rcd_wait_R6: assert property (@(posedge clk) disable iff (rst)
        (row_req && row_grant && row_is_act) |=> (!row_req && !col_req));

    assert_retire_gap_R9: assert property (@(posedge clk) disable iff (rst)
        (col_req && col_grant) |=> (!idle && !row_req && !col_req));

    assert_retire_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (col_req && col_grant) |=> ##1 idle);

    assert_fields_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!idle && !$past(idle)) |-> ($stable(cmd_row) && $stable(cmd_col)));
endmodule

bind bank_req_machine bm_checker #(.ROW_W(ROW_W), .COL_W(COL_W)) u_bm_checker (.*);

// File: tb/bank_req_machine_bench.sv
module bank_req_machine_bench;
    localparam int RANK_W = 1;
    localparam int BANK_W = 3;
    localparam int ROW_W  = 14;
    localparam int COL_W  = 10;
    localparam int T_RP   = 3;
    localparam int T_RCD  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [RANK_W-1:0] req_rank = '0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic refresh_busy = 1'b0, nbr_open = 1'b0;
    logic [RANK_W-1:0] nbr_rank = '0;
    logic [BANK_W-1:0] nbr_bank = '0;
    logic [ROW_W-1:0]  nbr_row = '0;
    logic row_grant = 1'b0, col_grant = 1'b0, col_allowed = 1'b1;
    logic idle, row_req, row_is_act, col_req, col_is_write;
    logic [RANK_W-1:0] cmd_rank;
    logic [BANK_W-1:0] cmd_bank;
    logic [ROW_W-1:0]  cmd_row;
    logic [COL_W-1:0]  cmd_col;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // bench-side open-row record
    bit m_v = 0;
    int m_rank = 0, m_bank = 0, m_row = 0;

    always #4 clk = ~clk;

    bank_req_machine #(
        .RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
        .T_RP(T_RP), .T_RCD(T_RCD)
    ) u_bank_req_machine (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_rank(req_rank),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_write(req_write), .idle(idle), .refresh_busy(refresh_busy),
        .nbr_open(nbr_open), .nbr_rank(nbr_rank), .nbr_bank(nbr_bank),
        .nbr_row(nbr_row), .row_req(row_req), .row_grant(row_grant),
        .row_is_act(row_is_act), .col_req(col_req), .col_grant(col_grant),
        .col_allowed(col_allowed), .col_is_write(col_is_write),
        .cmd_rank(cmd_rank), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .cmd_col(cmd_col)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // 0 = hit, 1 = conflict, 2 = closed
    function automatic int decide(input int rk, input int bk, input int rw);
        if (m_v && m_rank == rk && m_bank == bk) return (m_row == rw) ? 0 : 1;
        if (nbr_open && int'(nbr_rank) == rk && int'(nbr_bank) == bk)
            return (int'(nbr_row) == rw) ? 0 : 1;
        return 2;
    endfunction

    task automatic run_req(input int rk, input int bk, input int rw, input int cl,
                           input bit wr, input int exp_kind, input bit do_refresh,
                           input bit do_block, input string rq);
        int kind;
        int n;
        bit stray;
        kind = decide(rk, bk, rw);
        chk(kind == exp_kind, {rq, " bench path"}, kind, exp_kind);
        chk(idle == 1'b1, "R10 idle before accept", idle, 1);
        req_rank = RANK_W'(rk); req_bank = BANK_W'(bk); req_row = ROW_W'(rw);
        req_col = COL_W'(cl); req_write = wr; req_valid = 1'b1;
        tick();
        req_valid = 1'b0;
        #1;
        if (kind == 0) begin
            chk(col_req == 1'b1 && row_req == 1'b0, {rq, " R2 hit goes to column"},
                {30'd0, row_req, col_req}, 1);
        end else begin
            chk(row_req == 1'b1, {rq, " row request raised"}, row_req, 1);
            chk(int'(row_is_act) == (kind == 2 ? 1 : 0),
                {rq, kind == 2 ? " R4 first row cmd" : " R3 first row cmd"},
                row_is_act, kind == 2 ? 1 : 0);
            chk(cmd_bank == BANK_W'(bk) && cmd_rank == RANK_W'(rk),
                {rq, " R10 row target"}, cmd_bank, bk);
            if (do_refresh) begin
                refresh_busy = 1'b1;
                for (int i = 0; i < 3; i++) begin
                    row_grant = (i == 1);
                    #1;
                    chk(row_req == 1'b0, {rq, " R7 held in refresh"}, row_req, 0);
                    tick();
                end
                refresh_busy = 1'b0;
                row_grant = 1'b0;
                #1;
                chk(row_req == 1'b1 && int'(row_is_act) == (kind == 2 ? 1 : 0),
                    {rq, " R7 same request after refresh"}, row_req, 1);
            end
            if (kind == 1) begin
                row_grant = 1'b1;
                tick();
                row_grant = 1'b0;
                #1;
                n = 1;
                stray = 0;
                while (!row_req && n < 60) begin
                    if (col_req) stray = 1;
                    tick(); #1; n++;
                end
                chk(n == T_RP + 1, {rq, " R5 precharge to activate"}, n, T_RP + 1);
                chk(!stray && row_is_act == 1'b1, {rq, " R3 activate follows"}, row_is_act, 1);
                if (m_v && m_rank == rk && m_bank == bk) m_v = 0;
            end
            row_grant = 1'b1;
            tick();
            row_grant = 1'b0;
            #1;
            m_v = 1; m_rank = rk; m_bank = bk; m_row = rw;
            n = 1;
            stray = 0;
            while (!col_req && n < 60) begin
                if (row_req) stray = 1;
                tick(); #1; n++;
            end
            chk(n == T_RCD + 1, {rq, " R6 activate to column"}, n, T_RCD + 1);
            chk(!stray, {rq, " R6 quiet during wait"}, stray, 0);
            chk(cmd_row == ROW_W'(rw), {rq, " R10 activate row"}, cmd_row, rw);
        end
        if (do_block) begin
            col_allowed = 1'b0;
            for (int i = 0; i < 2; i++) begin
                req_valid = 1'b1;
                req_row = ROW_W'(rw ^ 1);
                req_col = COL_W'(cl ^ 1);
                #1;
                chk(col_req == 1'b0, {rq, " R8 column blocked"}, col_req, 0);
                tick();
            end
            req_valid = 1'b0;
            col_allowed = 1'b1;
            #1;
        end
        chk(col_req == 1'b1, {rq, " R8 column raised"}, col_req, 1);
        chk(col_is_write == wr, {rq, " R8 column type"}, col_is_write, wr);
        chk(cmd_col == COL_W'(cl) && cmd_row == ROW_W'(rw),
            {rq, " R10 fields kept"}, cmd_col, cl);
        col_grant = 1'b1;
        tick();
        col_grant = 1'b0;
        #1;
        chk(idle == 1'b0 && col_req == 1'b0 && row_req == 1'b0,
            {rq, " R9 retire gap"}, idle, 0);
        tick();
        #1;
        chk(idle == 1'b1, {rq, " R9 back to idle"}, idle, 1);
    endtask

    initial begin
        repeat (3) tick();
        #1;
        chk(idle == 1'b1 && row_req == 1'b0 && col_req == 1'b0, "R1 reset state", idle, 1);
        rst = 1'b0;
        tick();
        #1;
        // R1/R4: first request after reset activates
        run_req(0, 1, 5, 3, 1'b0, 2, 1'b0, 1'b0, "R1 R4 first");
        // R2: same rank/bank/row hits own record
        run_req(0, 1, 5, 7, 1'b1, 0, 1'b0, 1'b0, "R2 own hit");
        // R3 + refresh collision R7 + column block R8
        run_req(0, 1, 9, 12, 1'b1, 1, 1'b1, 1'b1, "R3 conflict");
        run_req(1, 1, 9, 2, 1'b0, 2, 1'b0, 1'b0, "R4 other rank");
        // neighbour-reported open row
        nbr_open = 1'b1; nbr_rank = 0; nbr_bank = 2; nbr_row = 20;
        run_req(0, 2, 20, 4, 1'b0, 0, 1'b0, 1'b0, "R2 neighbour hit");
        run_req(0, 2, 21, 5, 1'b1, 1, 1'b0, 1'b0, "R3 neighbour conflict");
        // own record (row 21) overrides neighbour (row 20)
        run_req(0, 2, 21, 6, 1'b0, 0, 1'b0, 1'b0, "R11 own priority");
        // precharge from neighbour conflict kept own record on other bank
        run_req(0, 2, 20, 8, 1'b1, 1, 1'b0, 1'b0, "R11 own conflict");
        nbr_open = 1'b0;
        // sweep over small bank/row set
        for (int i = 0; i < 36; i++) begin
            int bk, rw, k;
            bk = i % 3;
            rw = (i * 5) % 4;
            k = decide(i % 2, bk, rw);
            run_req(i % 2, bk, rw, i, 1'(i), k, 1'(i % 7 == 3), 1'(i % 5 == 2), "R11 sweep");
        end
        finish_run();
    end
endmodule